// File: doc/BRIEF.md
# System Control Register File

This block is a bank of privileged control registers that a processor reaches through a coprocessor register-transfer port. Each request carries a primary register index, a secondary index, two opcode fields, a read or write strobe, write data and a flag that says whether the processor is in user mode. The block checks the request against a legality rule that belongs to the addressed register. It answers one cycle later with an accept or reject flag and, for accepted reads, the register contents.

Two views share the primary index space. Opcode_2 equal to zero selects the main view. Any other opcode_2 selects the alternate view, which holds the cache-type word and an auxiliary control word. Accepted writes pass through a per-register keep mask, and the main control word also has fixed-one bits. One bit of the control word drives the byte-order output. A change of that bit raises a one-cycle pulse. Cache-maintenance and TLB requests are accepted where the rules allow them, but they have no effect and read as zero.

Top module: `sysctl_regfile`

## Requirements
- R1: A request is rejected when the user-mode flag is high, when opcode_1 is nonzero, or when both strobes are high. A rejected request changes no state and returns zero data.
- R2: After reset, index 0 reads 0x69052000 with opcode_2 = 0 and 0x0B1AA1AA with opcode_2 ≠ 0. Index 1 with opcode_2 = 0 reads 0x00000078. Every other stored word reads 0.
- R3: Legality by index:
  - 0 and 1: secondary index (CRm) 0, any opcode_2.
  - 2, 3, 5, 6 and 13: CRm 0 and opcode_2 0.
  - 7, by opcode_2: 0 takes CRm 5–7; 1 takes CRm 5, 6 or 10; 4 takes CRm 10; 5 takes CRm 2; 6 takes CRm 5; any other opcode_2 is rejected.
  - 8: CRm 5–7, except opcode_2 1 with CRm 7.
  - 9: opcode_2 0 or 1 with CRm 1 or 2.
  - 10: opcode_2 0 or 1 with CRm 4 or 8.
  - 14: opcode_2 0 with CRm 0, 3, 4, 8 or 9.
  - 15: CRm 1 and opcode_2 0.
  - 4, 11 and 12: always rejected.
- R4: For indices 0 and 1, opcode_2 ≠ 0 selects the alternate view: cache type and auxiliary control.
- R5: A control-word write (index 1, opcode_2 0) keeps written bits 13:11, 9:7 and 2:0. It forces bits 6:3 to 1 and all other bits to 0. Bit 7 of the control word is the `big_endian` output.
- R6: Write masks:
  - translation base keeps 31:14;
  - fault status keeps 10:9 and 7:0;
  - process ID keeps 31:25;
  - cache lock (index 9) keeps bit 0;
  - access word (index 15) keeps 13:0;
  - auxiliary keeps 5:4 and 1:0;
  - domain and fault address keep all bits;
  - writes to index 0 in either view are ignored.
- R7: Index 14 reaches five fully writable debug words, chosen by CRm 0, 3, 4, 8 and 9.
- R8: `resp_valid` is high exactly one cycle after a strobe. `rd_data` is zero for write responses, for rejects, and for accepted indices 7, 8 and 10.
- R9: `endian_flip` is high for exactly the response cycle of an accepted control write that changes bit 7. `big_endian` changes only together with that pulse.
- R10: A read issued in the cycle right after an accepted write returns the masked value of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| prim_idx | input | 4 | Primary register index |
| sub_idx | input | 4 | Secondary index (CRm) |
| op_a | input | 3 | Opcode_1, must be zero |
| op_b | input | 3 | Opcode_2, selects view and variant |
| wr_data | input | 32 | Write data |
| user_mode | input | 1 | Requester is unprivileged |
| resp_valid | output | 1 | Response present |
| resp_ok | output | 1 | Request accepted |
| rd_data | output | 32 | Read data, zero unless accepted read |
| big_endian | output | 1 | Byte-order control bit |
| endian_flip | output | 1 | One-cycle pulse on byte-order change |

## Verification
Two functions can land in the same cycle:
- A control-word write that toggles the byte-order bit. Its response, the `endian_flip` pulse and the new `big_endian` level all appear on one edge.
- A write response followed at once by a read of the same location.

The bench walks every index, CRm and opcode_2 combination with back-to-back write-then-read pairs, using data patterns that toggle bit 7 in many steps. On every response it compares the pulse, the level, the accept flag and the data against a bench model built from the mask and legality rules.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned OPC_W    = 3;
  localparam int unsigned DBG_N    = 5;
  localparam int unsigned ENDIAN_B = 7;

  localparam logic [DATA_W-1:0] ID_WORD     = 32'h6905_2000;
  localparam logic [DATA_W-1:0] CTYPE_WORD  = 32'h0B1A_A1AA;
  localparam logic [DATA_W-1:0] CTRL_RESET  = 32'h0000_0078;
  localparam logic [DATA_W-1:0] CTRL_KEEP   = 32'h0000_3B87;
  localparam logic [DATA_W-1:0] CTRL_ONES   = 32'h0000_0078;
  localparam logic [DATA_W-1:0] AUX_KEEP    = 32'h0000_0033;
  localparam logic [DATA_W-1:0] TBASE_KEEP  = 32'hFFFF_C000;
  localparam logic [DATA_W-1:0] FSTAT_KEEP  = 32'h0000_06FF;
  localparam logic [DATA_W-1:0] PID_KEEP    = 32'hFE00_0000;
  localparam logic [DATA_W-1:0] LOCK_KEEP   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] ACCESS_KEEP = 32'h0000_3FFF;

  // CRm code that selects each debug word under index 14
  function automatic logic [IDX_W-1:0] dbg_code(input int unsigned slot);
    case (slot)
      0:       dbg_code = 4'd0;
      1:       dbg_code = 4'd3;
      2:       dbg_code = 4'd4;
      3:       dbg_code = 4'd8;
      default: dbg_code = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check
  import sysctl_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] sub,
  input  logic [OPC_W-1:0] op1,
  input  logic [OPC_W-1:0] op2,
  input  logic             user,
  input  logic             rd,
  input  logic             wr,
  output logic             legal
);
  logic gate_ok;
  logic rule_ok;
  logic sub0;
  logic op0;

  assign gate_ok = !user && (op1 == '0) && (rd ^ wr);
  assign sub0    = (sub == '0);
  assign op0     = (op2 == '0);

  always_comb begin
    rule_ok = 1'b0;
    case (idx)
      4'd0, 4'd1: rule_ok = sub0;
      4'd2, 4'd3, 4'd5, 4'd6, 4'd13: rule_ok = sub0 && op0;
      4'd7: begin
        case (op2)
          3'd0:    rule_ok = (sub >= 4'd5) && (sub <= 4'd7);
          3'd1:    rule_ok = (sub == 4'd5) || (sub == 4'd6) || (sub == 4'd10);
          3'd4:    rule_ok = (sub == 4'd10);
          3'd5:    rule_ok = (sub == 4'd2);
          3'd6:    rule_ok = (sub == 4'd5);
          default: rule_ok = 1'b0;
        endcase
      end
      4'd8:  rule_ok = (sub >= 4'd5) && (sub <= 4'd7) && !((op2 == 3'd1) && (sub == 4'd7));
      4'd9:  rule_ok = (op2 <= 3'd1) && ((sub == 4'd1) || (sub == 4'd2));
      4'd10: rule_ok = (op2 <= 3'd1) && ((sub == 4'd4) || (sub == 4'd8));
      4'd14: rule_ok = op0 && ((sub == 4'd0) || (sub == 4'd3) || (sub == 4'd4) ||
                               (sub == 4'd8) || (sub == 4'd9));
      4'd15: rule_ok = (sub == 4'd1) && op0;
      default: rule_ok = 1'b0;
    endcase
  end

  assign legal = gate_ok && rule_ok;
endmodule

// File: rtl/sysctl_storage.sv
module sysctl_storage
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  sub,
  input  logic [OPC_W-1:0]  op2,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              endian,
  output logic              flip
);
  logic alt_view;
  assign alt_view = (op2 != '0);

  logic [DATA_W-1:0] ctrl_q, aux_q, tbase_q, dom_q, fstat_q, faddr_q, lock_q, pid_q, cacc_q;
  logic [DATA_W-1:0] ctrl_d, aux_d, tbase_d, dom_d, fstat_d, faddr_d, lock_d, pid_d, cacc_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    aux_d   = aux_q;
    tbase_d = tbase_q;
    dom_d   = dom_q;
    fstat_d = fstat_q;
    faddr_d = faddr_q;
    lock_d  = lock_q;
    pid_d   = pid_q;
    cacc_d  = cacc_q;
    if (we) begin
      case (idx)
        4'd1: begin
          if (alt_view) aux_d  = wdata & AUX_KEEP;
          else          ctrl_d = (wdata & CTRL_KEEP) | CTRL_ONES;
        end
        4'd2:  tbase_d = wdata & TBASE_KEEP;
        4'd3:  dom_d   = wdata;
        4'd5:  fstat_d = wdata & FSTAT_KEEP;
        4'd6:  faddr_d = wdata;
        4'd9:  lock_d  = wdata & LOCK_KEEP;
        4'd13: pid_d   = wdata & PID_KEEP;
        4'd15: cacc_d  = wdata & ACCESS_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      aux_q   <= '0;
      tbase_q <= '0;
      dom_q   <= '0;
      fstat_q <= '0;
      faddr_q <= '0;
      lock_q  <= '0;
      pid_q   <= '0;
      cacc_q  <= '0;
    end else if (we) begin
      ctrl_q  <= ctrl_d;
      aux_q   <= aux_d;
      tbase_q <= tbase_d;
      dom_q   <= dom_d;
      fstat_q <= fstat_d;
      faddr_q <= faddr_d;
      lock_q  <= lock_d;
      pid_q   <= pid_d;
      cacc_q  <= cacc_d;
    end
  end

  // Debug words under index 14, one register per CRm code
  logic [DATA_W-1:0] dbg_q   [DBG_N];
  logic [DBG_N-1:0]  dbg_hit;

  for (genvar g = 0; g < DBG_N; g++) begin : g_dbg
    assign dbg_hit[g] = (idx == 4'd14) && (sub == dbg_code(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 dbg_q[g] <= '0;
      else if (we && dbg_hit[g])  dbg_q[g] <= wdata;
    end
  end

  logic [DATA_W-1:0] dbg_rd;
  always_comb begin
    dbg_rd = '0;
    for (int i = 0; i < DBG_N; i++) begin
      if (dbg_hit[i]) dbg_rd = dbg_rd | dbg_q[i];
    end
  end

  always_comb begin
    case (idx)
      4'd0:  rdata = alt_view ? CTYPE_WORD : ID_WORD;
      4'd1:  rdata = alt_view ? aux_q : ctrl_q;
      4'd2:  rdata = tbase_q;
      4'd3:  rdata = dom_q;
      4'd5:  rdata = fstat_q;
      4'd6:  rdata = faddr_q;
      4'd9:  rdata = lock_q;
      4'd13: rdata = pid_q;
      4'd14: rdata = dbg_rd;
      4'd15: rdata = cacc_q;
      default: rdata = '0;
    endcase
  end

  assign endian = ctrl_q[ENDIAN_B];
  assign flip   = we && (idx == 4'd1) && !alt_view && (wdata[ENDIAN_B] != ctrl_q[ENDIAN_B]);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  prim_idx,
  input  logic [IDX_W-1:0]  sub_idx,
  input  logic [OPC_W-1:0]  op_a,
  input  logic [OPC_W-1:0]  op_b,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              user_mode,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              big_endian,
  output logic              endian_flip
);
  logic              legal;
  logic              wr_take;
  logic [DATA_W-1:0] st_rdata;
  logic              st_flip;

  sysctl_access_check u_check (
    .idx  (prim_idx),
    .sub  (sub_idx),
    .op1  (op_a),
    .op2  (op_b),
    .user (user_mode),
    .rd   (acc_rd),
    .wr   (acc_wr),
    .legal(legal)
  );

  assign wr_take = acc_wr && legal;

  sysctl_storage u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_take),
    .idx   (prim_idx),
    .sub   (sub_idx),
    .op2   (op_b),
    .wdata (wr_data),
    .rdata (st_rdata),
    .endian(big_endian),
    .flip  (st_flip)
  );

  logic              valid_d, ok_d, flip_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = acc_rd || acc_wr;
    ok_d    = legal;
    flip_d  = st_flip;
    data_d  = (acc_rd && legal) ? st_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_ok     <= 1'b0;
      rd_data     <= '0;
      endian_flip <= 1'b0;
    end else begin
      resp_valid  <= valid_d;
      resp_ok     <= ok_d;
      rd_data     <= data_d;
      endian_flip <= flip_d;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [IDX_W-1:0]  prim_idx,
  input logic [IDX_W-1:0]  sub_idx,
  input logic [OPC_W-1:0]  op_a,
  input logic [OPC_W-1:0]  op_b,
  input logic              user_mode,
  input logic              resp_valid,
  input logic              resp_ok,
  input logic [DATA_W-1:0] rd_data,
  input logic              big_endian,
  input logic              endian_flip
);
  assert_user_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && user_mode) |=> (resp_valid && !resp_ok && rd_data == '0));

  assert_opcode1_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && op_a != '0) |=> !resp_ok);

  assert_never_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && (prim_idx == 4'd4 || prim_idx == 4'd11 || prim_idx == 4'd12))
      |=> (resp_valid && !resp_ok));

  assert_ctrl_fixed_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr && !user_mode && op_a == '0 && prim_idx == 4'd1 &&
     sub_idx == '0 && op_b == '0)
      |=> (resp_ok && rd_data[6:3] == 4'hF && rd_data[31:14] == '0 && !rd_data[10]));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd && !acc_wr) |=> (!resp_valid && !resp_ok && rd_data == '0 && !endian_flip));

  assert_reject_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> (rd_data == '0 && !endian_flip));

  assert_flip_changes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    endian_flip |-> (big_endian != $past(big_endian)));

  assert_endian_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !endian_flip |-> $stable(big_endian));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (.*);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_rd, acc_wr, user_mode;
  logic [3:0]  prim_idx, sub_idx;
  logic [2:0]  op_a, op_b;
  logic [31:0] wr_data;
  logic        resp_valid, resp_ok, big_endian, endian_flip;
  logic [31:0] rd_data;

  always #4 clk = ~clk;  // 125 MHz

  sysctl_regfile u_sysctl_regfile (.*);

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // model state: slot 0 id, 1 cache type, 2 control, 3 aux, 4 tbase, 5 domain,
  // 6 fault status, 7 fault address, 8 lock, 9 pid, 10 access, 11..15 debug
  logic [31:0] m_val  [16];
  logic [31:0] m_keep [16];
  logic [31:0] m_ones [16];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!cond) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit legal_m(input int idx, input int crm, input int op2);
    case (idx)
      0, 1: return crm == 0;
      2, 3, 5, 6, 13: return crm == 0 && op2 == 0;
      7: begin
        if (op2 == 0) return crm >= 5 && crm <= 7;
        if (op2 == 1) return crm == 5 || crm == 6 || crm == 10;
        if (op2 == 4) return crm == 10;
        if (op2 == 5) return crm == 2;
        if (op2 == 6) return crm == 5;
        return 1'b0;
      end
      8: return crm >= 5 && crm <= 7 && !(op2 == 1 && crm == 7);
      9: return op2 <= 1 && (crm == 1 || crm == 2);
      10: return op2 <= 1 && (crm == 4 || crm == 8);
      14: return op2 == 0 && (crm == 0 || crm == 3 || crm == 4 || crm == 8 || crm == 9);
      15: return crm == 1 && op2 == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int slot_m(input int idx, input int crm, input int op2);
    case (idx)
      0: return (op2 == 0) ? 0 : 1;
      1: return (op2 == 0) ? 2 : 3;
      2: return 4;
      3: return 5;
      5: return 6;
      6: return 7;
      9: return 8;
      13: return 9;
      15: return 10;
      14: begin
        if (crm == 0) return 11;
        if (crm == 3) return 12;
        if (crm == 4) return 13;
        if (crm == 8) return 14;
        return 15;
      end
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input int slot);
    if (slot == 2) return "R5";
    if (slot >= 11) return "R7";
    return "R6";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_val[i]  = 32'h0;
      m_keep[i] = 32'hFFFF_FFFF;
      m_ones[i] = 32'h0;
    end
    m_val[0] = 32'h6905_2000;  m_keep[0] = 32'h0;
    m_val[1] = 32'h0B1A_A1AA;  m_keep[1] = 32'h0;
    m_val[2] = 32'h0000_0078;  m_keep[2] = 32'h0000_3B87; m_ones[2] = 32'h0000_0078;
    m_keep[3]  = 32'h0000_0033;
    m_keep[4]  = 32'hFFFF_C000;
    m_keep[6]  = 32'h0000_06FF;
    m_keep[8]  = 32'h0000_0001;
    m_keep[9]  = 32'hFE00_0000;
    m_keep[10] = 32'h0000_3FFF;
  endtask

  // Drive one request at a falling edge, sample its response one cycle later.
  task automatic do_acc(input bit rd, input bit wr, input int idx, input int crm,
                        input int op1, input int op2, input logic [31:0] wd,
                        input bit usr, input string dtag);
    bit          e_ok, e_flip;
    logic [31:0] e_rd;
    int          s;
    string       otag;
    e_ok   = legal_m(idx, crm, op2) && !usr && op1 == 0 && (rd ^ wr);
    s      = slot_m(idx, crm, op2);
    e_rd   = 32'h0;
    e_flip = 1'b0;
    if (rd && e_ok && s >= 0) e_rd = m_val[s];
    if (wr && e_ok && s >= 0 && m_keep[s] != 32'h0) begin
      logic [31:0] nv;
      nv = (wd & m_keep[s]) | m_ones[s];
      if (s == 2) e_flip = (nv[7] != m_val[2][7]);
      m_val[s] = nv;
    end
    acc_rd = rd; acc_wr = wr; prim_idx = idx[3:0]; sub_idx = crm[3:0];
    op_a = op1[2:0]; op_b = op2[2:0]; wr_data = wd; user_mode = usr;
    @(posedge clk);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0; user_mode = 1'b0;
    otag = (usr || op1 != 0 || (rd && wr)) ? "R1" : "R3";
    chk(resp_valid == 1'b1, "R8 valid", {31'b0, resp_valid}, 32'h1);
    chk(resp_ok == e_ok, otag, {31'b0, resp_ok}, {31'b0, e_ok});
    chk(rd_data == e_rd, wr ? "R8 write data" : dtag, rd_data, e_rd);
    chk(endian_flip == e_flip, "R9 pulse", {31'b0, endian_flip}, {31'b0, e_flip});
    chk(big_endian == m_val[2][7], "R5 endian", {31'b0, big_endian}, {31'b0, m_val[2][7]});
  endtask

  task automatic read_sweep(input string tg);
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 16; c++)
        for (int o = 0; o < 8; o++)
          do_acc(1'b1, 1'b0, i, c, 0, o, 32'h0, 1'b0,
                 ((i == 0 || i == 1) && o != 0) ? "R4" : tg);
  endtask

  initial begin
    rst_n = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0; user_mode = 1'b0;
    prim_idx = '0; sub_idx = '0; op_a = '0; op_b = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(resp_valid == 1'b0, "R8 reset valid", {31'b0, resp_valid}, 32'h0);
    chk(big_endian == 1'b0, "R2 reset endian", {31'b0, big_endian}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp_valid == 1'b0 && rd_data == 32'h0, "R8 idle", rd_data, 32'h0);

    // reset contents of every legal combination, both views (R2, R4)
    read_sweep("R2");

    // byte-order toggling (R9, R5)
    do_acc(1'b0, 1'b1, 1, 0, 0, 0, 32'h0000_0080, 1'b0, "R9");
    do_acc(1'b0, 1'b1, 1, 0, 0, 0, 32'hFFFF_FFFF, 1'b0, "R9");
    do_acc(1'b1, 1'b0, 1, 0, 0, 0, 32'h0, 1'b0, "R5");
    do_acc(1'b0, 1'b1, 1, 0, 0, 0, 32'h0000_0000, 1'b0, "R9");
    do_acc(1'b1, 1'b0, 1, 0, 0, 0, 32'h0, 1'b0, "R5");
    do_acc(1'b0, 1'b1, 1, 3, 0, 0, 32'h0000_0080, 1'b0, "R3");

    // write every combination, read it back the next cycle (R10, R5, R6, R7)
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 16; c++)
        for (int o = 0; o < 8; o++) begin
          logic [31:0] wd;
          int s;
          wd = 32'h9E37_79B9 * (i * 128 + c * 8 + o + 1);
          s  = slot_m(i, c, o);
          do_acc(1'b0, 1'b1, i, c, 0, o, wd, 1'b0, "R8");
          do_acc(1'b1, 1'b0, i, c, 0, o, 32'h0, 1'b0, (s >= 0) ? tag_of(s) : "R10");
        end

    // rejected requests must leave state untouched (R1)
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 16; c++)
        do_acc(1'b0, 1'b1, i, c, 0, 0, 32'h5A5A_F0F0 ^ i, 1'b1, "R1");
    for (int p = 1; p < 8; p++) begin
      do_acc(1'b0, 1'b1, 3, 0, p, 0, 32'h1234_5678, 1'b0, "R1");
      do_acc(1'b1, 1'b0, 1, 0, p, 0, 32'h0, 1'b0, "R1");
    end
    do_acc(1'b1, 1'b1, 3, 0, 0, 0, 32'hDEAD_BEEF, 1'b0, "R1");
    do_acc(1'b1, 1'b1, 1, 0, 0, 0, 32'h0000_0000, 1'b0, "R1");
    do_acc(1'b1, 1'b0, 3, 0, 0, 0, 32'h0, 1'b1, "R1");
    read_sweep("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule